// File: doc/BRIEF.md
# Absolute Position Serial Slave Transmitter

This block is the slave end of a clocked point-to-point serial link that reports a 12-bit absolute position. A master toggles a clock line; the slave captures its position and error inputs into a snapshot on the first falling edge. It then returns one response bit for each clock period on its data output. The response is a short header, the position word, a status pair and an inverted 6-bit check code.

Once its own response has been sent, the slave passes the serial data from the next device in a chain through to its output. Several sensors can therefore share one master clock and be read in a single burst. The master ends a transfer by holding its clock still. After a programmable number of system clock cycles without a clock edge, the slave returns to idle and drives its output high.

The master clock is sampled by the fast system clock through a synchronizer. The system clock must run at least four times faster than the master clock. The maximum master clock rate is 10 MHz. Only one response is produced per transfer.

Top module: `abs_pos_slave_tx`

## Requirements
- R1: After reset, and whenever the slave is idle, `slo_o` is 1.
- R2: `pos_i` and `err_i` are captured on the first falling edge of `ma_i` seen while idle. Later changes to either input do not alter the response of that transfer.
- R3: The response has 23 bits. One bit is presented per `ma_i` period and changes on its rising edge. The first rising edge after capture presents bit 0. Bits 0..2 are the header values 0, 1, 0.
- R4: Bits 3..14 carry the captured position, MSB first. Bit 15 carries the inverse of the captured `err_i`, so it is 0 when an error is reported.
- R5: Bit 16 is always 1.
- R6: Bits 17..22 are the inverse of a 6-bit CRC, sent MSB first. The CRC uses generator x^6+x+1 and starts from zero. It covers bits 3..16 in send order.
- R7: From the 24th rising edge of the transfer onward, `slo_o` follows `sli_i` with one system clock of delay. Before that, `sli_i` has no effect on `slo_o`.
- R8: If no edge is seen on `ma_i` for TIMEOUT_CYC system clocks during a transfer, the slave returns to idle with `slo_o` high. The next falling edge then starts a new capture.
- R9: A rising edge of `ma_i` takes effect at `slo_o` on the third system clock edge after the change, with the default two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_i | input | 1 | Master serial clock, asynchronous, idles high |
| sli_i | input | 1 | Serial data from the next slave in the chain |
| pos_i | input | 12 | Absolute position to report |
| err_i | input | 1 | Internal error flag, active high |
| slo_o | output | 1 | Serial response data to the master |

## Verification
A corrupted snapshot or a wrong CRC step appears as a bad bit at `slo_o` within the same master clock period. A CRC error may only show in the last six bits. A bit counter that is off by one shifts every later field and lets the chained input appear one period early or late. The bench therefore compares every bit of every response, including the passthrough bits. A timer or state fault shows within one timeout window as an output that fails to return high, or as a failure to capture on the next transfer.

// File: rtl/abs_enc_pkg.sv
package abs_enc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_PASS  = 2'd2
  } tx_state_e;

  // Header sent ahead of the data: acknowledge 0, start 1, control 0
  localparam int unsigned HDR_W = 3;
  localparam logic [HDR_W-1:0] HDR_BITS = 3'b010;

endpackage

// File: rtl/ma_edge_sync.sv
module ma_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ma_i,
  output logic rise_o,
  output logic fall_o,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              ma_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ma_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ma_s   = sync_q[STAGES-1];
  assign rise_o = ma_s & ~last_q;
  assign fall_o = ~ma_s & last_q;
  assign edge_o = rise_o | fall_o;

  // R9
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import abs_enc_pkg::*;
#(
  parameter int unsigned   POS_W    = 12,
  parameter int unsigned   CRC_W    = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'b000011,
  localparam int unsigned  COV_W    = POS_W + 2,
  localparam int unsigned  FRAME_W  = HDR_W + COV_W + CRC_W
) (
  input  logic [POS_W-1:0]   pos_i,
  input  logic               err_i,
  output logic [FRAME_W-1:0] frame_o
);

  function automatic logic [CRC_W-1:0] crc_of(input logic [COV_W-1:0] bits);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = COV_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ bits[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [COV_W-1:0] covered;
  logic [CRC_W-1:0] crc;

  always_comb begin
    covered = {pos_i, ~err_i, 1'b1};
    crc     = crc_of(covered);
    frame_o = {HDR_BITS, covered, ~crc};
  end

endmodule

// File: rtl/timeout_timer.sv
module timeout_timer #(
  parameter int unsigned TIMEOUT_CYC = 40,
  localparam int unsigned LIM_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic edge_i,
  output logic expire_o
);

  logic [LIM_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active_i || edge_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM_W'(TIMEOUT_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = active_i && !edge_i && (cnt_q == LIM_W'(TIMEOUT_CYC - 1));

  // R8
  restart_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> cnt_q == '0);

  // R8
  bounded_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_W'(TIMEOUT_CYC));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import abs_enc_pkg::*;
#(
  parameter int unsigned FRAME_W = 23,
  parameter int unsigned NW_IDX  = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               timeout_i,
  input  logic               sli_i,
  input  logic [FRAME_W-1:0] frame_i,
  output tx_state_e          state_o,
  output logic               slo_o
);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] shadow_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   idx;
  logic               frame_done;

  assign idx        = CNT_W'(FRAME_W - 1) - cnt_q;
  assign frame_done = (cnt_q == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TX_IDLE;
      shadow_q <= '0;
      cnt_q    <= '0;
      slo_o    <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          slo_o <= 1'b1;
          if (fall_i) begin
            shadow_q <= frame_i;
            cnt_q    <= '0;
            state_q  <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (timeout_i) begin
            state_q <= TX_IDLE;
            slo_o   <= 1'b1;
          end else if (rise_i) begin
            if (frame_done) begin
              state_q <= TX_PASS;
              slo_o   <= sli_i;
            end else begin
              slo_o <= shadow_q[idx];
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        TX_PASS: begin
          if (timeout_i) begin
            state_q <= TX_IDLE;
            slo_o   <= 1'b1;
          end else begin
            slo_o <= sli_i;
          end
        end
        default: begin
          state_q <= TX_IDLE;
          slo_o   <= 1'b1;
        end
      endcase
    end
  end

  assign state_o = state_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE && $past(state_q) == TX_IDLE) |-> slo_o);

  // R2
  snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SHIFT && $past(state_q) == TX_SHIFT) |-> $stable(shadow_q));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

  // R5
  warn_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SHIFT && rise_i && !timeout_i && cnt_q == CNT_W'(NW_IDX)) |=> slo_o);

  // R7
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_PASS && $past(state_q) == TX_PASS && !$past(timeout_i))
      |-> slo_o == $past(sli_i));

  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i && state_q != TX_IDLE) |=> (state_q == TX_IDLE && slo_o));

endmodule

// File: rtl/abs_pos_slave_tx.sv
module abs_pos_slave_tx
  import abs_enc_pkg::*;
#(
  parameter int unsigned POS_W       = 12,
  parameter int unsigned CRC_W       = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'b000011,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ma_i,
  input  logic             sli_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             err_i,
  output logic             slo_o
);

  localparam int unsigned FRAME_W = HDR_W + POS_W + 2 + CRC_W;
  localparam int unsigned NW_IDX  = HDR_W + POS_W + 1;

  logic               ma_rise;
  logic               ma_fall;
  logic               ma_edge;
  logic               timeout;
  logic [FRAME_W-1:0] frame;
  tx_state_e          state;

  ma_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ma_i   (ma_i),
    .rise_o (ma_rise),
    .fall_o (ma_fall),
    .edge_o (ma_edge)
  );

  frame_builder #(.POS_W(POS_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_frame (
    .pos_i   (pos_i),
    .err_i   (err_i),
    .frame_o (frame)
  );

  timeout_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (state != TX_IDLE),
    .edge_i   (ma_edge),
    .expire_o (timeout)
  );

  tx_shifter #(.FRAME_W(FRAME_W), .NW_IDX(NW_IDX)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (ma_rise),
    .fall_i    (ma_fall),
    .timeout_i (timeout),
    .sli_i     (sli_i),
    .frame_i   (frame),
    .state_o   (state),
    .slo_o     (slo_o)
  );

endmodule

// File: tb/abs_pos_slave_tx_tb.sv
module abs_pos_slave_tx_tb_top;

  localparam int HALF    = 10;
  localparam int TMO     = 40;
  localparam int FRAME_N = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ma_r = 1'b1;
  logic        sli_r = 1'b0;
  logic [11:0] pos_r = '0;
  logic        err_r = 1'b0;
  logic        slo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  abs_pos_slave_tx #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ma_i  (ma_r),
    .sli_i (sli_r),
    .pos_i (pos_r),
    .err_i (err_r),
    .slo_o (slo)
  );

  // CRC as a polynomial remainder: message times x^6 modulo x^6+x+1
  function automatic logic [5:0] ref_crc(input logic [13:0] msg);
    logic [19:0] v;
    v = {msg, 6'b0};
    for (int i = 19; i >= 6; i--)
      if (v[i]) v = v ^ (20'(7'b1000011) << (i - 6));
    return v[5:0];
  endfunction

  function automatic logic [22:0] ref_frame(input logic [11:0] p, input logic e);
    logic [13:0] m;
    m = {p, ~e, 1'b1};
    return {1'b0, 1'b1, 1'b0, m, ~ref_crc(m)};
  endfunction

  function automatic string tag_of(input int i);
    if (i < 3)   return "R3";
    if (i < 16)  return "R4";
    if (i == 16) return "R5";
    return "R6";
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic mclk_cycle(output logic got);
    ma_r = 1'b1;
    repeat (HALF) @(negedge clk);
    got = slo;
    ma_r = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic idle_wait_check(input string what);
    ma_r  = 1'b1;
    sli_r = 1'b0;
    repeat (TMO + 20) @(negedge clk);
    check(slo, 1'b1, "R8", what);
  endtask

  // Full transfer: capture, 23 response bits, n_pass chained bits, timeout
  task automatic send_frame(input logic [11:0] p, input logic e, input int n_pass);
    logic [22:0] exp;
    logic [11:0] rx_pos;
    logic        got;
    @(negedge clk);
    pos_r = p;
    err_r = e;
    exp   = ref_frame(p, e);
    ma_r  = 1'b0;
    repeat (HALF) @(negedge clk);
    // R2: inputs change after capture
    pos_r = 12'($urandom);
    err_r = 1'($urandom);
    for (int i = 0; i < FRAME_N; i++) begin
      sli_r = 1'($urandom);  // R7: ignored during own response
      mclk_cycle(got);
      check(got, exp[FRAME_N-1-i], tag_of(i), $sformatf("bit %0d pos=%03h err=%0b", i, p, e));
      if (i >= 3 && i < 15) rx_pos[14-i] = got;
      if (i == 10 || i == 14) pos_r = 12'($urandom);
    end
    n_tests++;
    if (rx_pos !== p) begin
      n_fail++;
      $display("FAIL R2 captured position: got %03h expected %03h", rx_pos, p);
    end
    for (int j = 0; j < n_pass; j++) begin
      logic s;
      s = 1'($urandom);
      sli_r = s;
      mclk_cycle(got);
      check(got, s, "R7", $sformatf("chained bit %0d", j));
    end
    idle_wait_check("return to idle after transfer");
  endtask

  initial begin
    logic got;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    check(slo, 1'b1, "R1", "output during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(slo, 1'b1, "R1", "idle output after reset");

    // R9: latency of a rising edge to the output
    pos_r = 12'h123;
    err_r = 1'b0;
    ma_r  = 1'b0;
    repeat (HALF) @(negedge clk);
    ma_r = 1'b1;
    repeat (2) @(negedge clk);
    check(slo, 1'b1, "R9", "output before third clock edge");
    @(negedge clk);
    check(slo, 1'b0, "R9", "acknowledge at third clock edge");
    idle_wait_check("timeout after probe");

    // Directed corners
    send_frame(12'h000, 1'b0, 2);
    send_frame(12'hFFF, 1'b1, 3);
    send_frame(12'hA5A, 1'b1, 0);
    send_frame(12'h800, 1'b0, 1);

    // R8: abort mid-response, then a clean new capture
    pos_r = 12'h3C3;
    err_r = 1'b0;
    ma_r  = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 9; i++) mclk_cycle(got);
    idle_wait_check("abort mid-response");
    send_frame(12'h0F0, 1'b0, 1);

    // Constrained random transfers
    for (int k = 0; k < 20; k++)
      send_frame(12'($urandom), 1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 4)));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule